// File: doc/BRIEF.md
# Processor Stream Write Unit

This unit sits beside a CPU pipeline and carries out stream write commands. Each command brings a 32-bit register value, a 4-bit index that picks one of sixteen stream master ports, a flag that picks blocking or non-blocking behaviour, and a flag that marks the beat as data or as control. Behind each port is a one-beat output register. An accepted command loads that register, and the register then offers the beat downstream on a valid/ready stream whose last-beat flag marks a packet boundary.

A port is *busy* in a cycle when its TVALID is high and its TREADY is low. A beat leaves only on a cycle in which TVALID and TREADY are both high. TDATA and TLAST do not change while a beat waits. Back-pressure on a port reaches the pipeline in one of two ways. A blocking command raises `stall` for as long as its port is busy. The pipeline holds the command steady during that time, and the command is accepted in the first cycle the port is free. A non-blocking command is always accepted in its own cycle. If the port was busy it is dropped, and the `carry` status reports the outcome.

Top module: `stream_put_unit`

## Requirements
- R1: During and after reset, every TVALID is low, and both `stall` and `carry` are low.
- R2: A blocking command to a port that is not busy leaves `stall` low. After the next clock edge, that port shows TVALID high with the command's value on TDATA.
- R3: A blocking command to a busy port holds `stall` high in every cycle the port stays busy. `stall` drops in the cycle that port's TREADY is high, and the new value appears after that clock edge.
- R4: A non-blocking command never raises `stall`. If its port is busy, that port's TDATA, TLAST and TVALID stay unchanged, and `carry` reads 1 after the clock edge.
- R5: A non-blocking command to a port that is not busy loads the beat and clears `carry` after the clock edge.
- R6: TLAST of the loaded beat is 1 when the command's control flag (`cmd_ctrl`) is 1 and 0 when it is 0.
- R7: While a port's TVALID is high and its TREADY is low, that port's TVALID, TDATA and TLAST stay stable.
- R8: After a cycle with TVALID and TREADY both high and no new write to that port, TVALID goes low.
- R9: A command loads only the port it selects. At most one port is loaded per cycle, and every other port's state stays as it was.
- R10: A blocking command leaves `carry` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | A write command is present this cycle |
| cmd_data | input | 32 | Register value to send |
| cmd_port | input | 4 | Target port index, 0 to 15 |
| cmd_nonblock | input | 1 | 1 = non-blocking, 0 = blocking |
| cmd_ctrl | input | 1 | 1 = control beat (TLAST high), 0 = data beat |
| stall | output | 1 | Pipeline hold request, combinational |
| carry | output | 1 | 1 = last non-blocking write was dropped |
| m_tvalid | output | 16 | Per-port TVALID, bit n is port n |
| m_tready | input | 16 | Per-port TREADY, bit n is port n |
| m_tdata | output | 512 | Per-port TDATA, port n at bits 32n+31:32n |
| m_tlast | output | 16 | Per-port TLAST, bit n is port n |

## Verification
A wrong busy decision shows up in the same cycle on `stall`. It shows up one edge later as a lost beat, or as a beat written over one that was still waiting on TDATA. A wrong port decode shows up one edge after the command, as TVALID rising on a port that was not selected. A stale `carry` register shows up right after the next non-blocking command. The bench keeps its own model of all sixteen output registers under random ready patterns and compares every port after every edge, so any such fault surfaces within one cycle of its cause.

// File: rtl/stream_put_pkg.sv
package stream_put_pkg;
  typedef enum logic {
    BEAT_DATA = 1'b0,
    BEAT_CTRL = 1'b1
  } beat_kind_e;

  function automatic logic beat_last(beat_kind_e kind);
    return kind == BEAT_CTRL;
  endfunction
endpackage

// File: rtl/stream_out_slot.sv
module stream_out_slot #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] ld_data,
  input  logic          ld_last,
  input  logic          tready,
  output logic          tvalid,
  output logic [DW-1:0] tdata,
  output logic          tlast,
  output logic          busy
);
  assign busy = tvalid & ~tready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tvalid <= 1'b0;
      tdata  <= '0;
      tlast  <= 1'b0;
    end else begin
      if (load) begin
        tvalid <= 1'b1;
        tdata  <= ld_data;
        tlast  <= ld_last;
      end else if (tready) begin
        tvalid <= 1'b0;
      end
    end
  end

  a_r7_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    tvalid && !tready |=> tvalid && $stable(tdata) && $stable(tlast));

  a_r8_drop_after_beat: assert property (@(posedge clk) disable iff (!rst_n)
    tvalid && tready && !load |=> !tvalid);

  a_r3_no_overwrite: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !(tvalid && !tready));
endmodule

// File: rtl/stream_put_ctrl.sv
module stream_put_ctrl #(
  parameter int NPORTS = 16,
  parameter int IDXW   = $clog2(NPORTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [IDXW-1:0]   cmd_port,
  input  logic              cmd_nonblock,
  input  logic [NPORTS-1:0] port_busy,
  output logic [NPORTS-1:0] load_vec,
  output logic              stall,
  output logic              carry
);
  logic in_range;
  logic sel_busy;
  logic accept;

  assign in_range = 32'(cmd_port) < NPORTS;
  assign sel_busy = in_range ? port_busy[cmd_port] : 1'b0;
  assign stall    = cmd_valid & ~cmd_nonblock & sel_busy;
  assign accept   = cmd_valid & in_range & ~sel_busy;

  for (genvar i = 0; i < NPORTS; i++) begin : g_dec
    assign load_vec[i] = accept & (cmd_port == IDXW'(i));
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      carry <= 1'b0;
    else if (cmd_valid && cmd_nonblock)
      carry <= sel_busy;
  end

  a_r4_nb_no_stall: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_nonblock |-> !stall);

  a_r4_carry_on_drop: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_nonblock && stall == 1'b0 && load_vec == '0 && in_range |=> carry);

  a_r10_blocking_keeps_carry: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_nonblock |=> $stable(carry));

  a_r9_single_load: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(load_vec));
endmodule

// File: rtl/stream_put_unit.sv
module stream_put_unit #(
  parameter int NPORTS = 16,
  parameter int DW     = 32,
  parameter int IDXW   = $clog2(NPORTS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cmd_valid,
  input  logic [DW-1:0]        cmd_data,
  input  logic [IDXW-1:0]      cmd_port,
  input  logic                 cmd_nonblock,
  input  logic                 cmd_ctrl,
  output logic                 stall,
  output logic                 carry,
  output logic [NPORTS-1:0]    m_tvalid,
  input  logic [NPORTS-1:0]    m_tready,
  output logic [NPORTS*DW-1:0] m_tdata,
  output logic [NPORTS-1:0]    m_tlast
);
  import stream_put_pkg::*;

  logic [NPORTS-1:0] load_vec;
  logic [NPORTS-1:0] port_busy;
  logic              ld_last;

  assign ld_last = beat_last(beat_kind_e'(cmd_ctrl));

  stream_put_ctrl #(.NPORTS(NPORTS), .IDXW(IDXW)) i_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .cmd_valid    (cmd_valid),
    .cmd_port     (cmd_port),
    .cmd_nonblock (cmd_nonblock),
    .port_busy    (port_busy),
    .load_vec     (load_vec),
    .stall        (stall),
    .carry        (carry)
  );

  for (genvar p = 0; p < NPORTS; p++) begin : g_port
    stream_out_slot #(.DW(DW)) i_slot (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (load_vec[p]),
      .ld_data (cmd_data),
      .ld_last (ld_last),
      .tready  (m_tready[p]),
      .tvalid  (m_tvalid[p]),
      .tdata   (m_tdata[p*DW +: DW]),
      .tlast   (m_tlast[p]),
      .busy    (port_busy[p])
    );
  end

  a_r1_reset_idle: assert property (@(posedge clk)
    !rst_n |=> m_tvalid == '0 && !carry);

  a_r2_load_shows: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !stall && !cmd_nonblock |=> m_tvalid[$past(cmd_port)]);

  a_r6_last_follows_kind: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_nonblock && !stall |=> m_tlast[$past(cmd_port)] == $past(cmd_ctrl));
endmodule

// File: tb/test_stream_put_unit.sv
`timescale 1ns/1ps
module test_stream_put_unit;
  localparam int NP = 16;
  localparam int DW = 32;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            cmd_valid;
  logic [DW-1:0]   cmd_data;
  logic [3:0]      cmd_port;
  logic            cmd_nb;
  logic            cmd_ctrl;
  logic            stall;
  logic            carry;
  logic [NP-1:0]   m_tvalid;
  logic [NP-1:0]   rdy;
  logic [NP*DW-1:0] m_tdata;
  logic [NP-1:0]   m_tlast;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  stream_put_unit i_stream_put_unit (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_data(cmd_data),
    .cmd_port(cmd_port), .cmd_nonblock(cmd_nb), .cmd_ctrl(cmd_ctrl),
    .stall(stall), .carry(carry), .m_tvalid(m_tvalid), .m_tready(rdy),
    .m_tdata(m_tdata), .m_tlast(m_tlast)
  );

  // {port[3:0], nonblock, ctrl, data[31:0]}
  localparam logic [37:0] VEC [8] = '{
    {4'd0,  1'b0, 1'b0, 32'h0000_0001},
    {4'd15, 1'b0, 1'b1, 32'hFFFF_FFFF},
    {4'd7,  1'b1, 1'b0, 32'hA5A5_5A5A},
    {4'd1,  1'b1, 1'b1, 32'h1234_5678},
    {4'd8,  1'b0, 1'b0, 32'h8000_0000},
    {4'd8,  1'b0, 1'b1, 32'h0BAD_F00D},
    {4'd14, 1'b1, 1'b0, 32'hDEAD_BEEF},
    {4'd2,  1'b0, 1'b1, 32'h0000_0000}
  };

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] pdata(input int p);
    return m_tdata[p*DW +: DW];
  endfunction

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    cmd_valid = 1'b0; cmd_data = '0; cmd_port = '0; cmd_nb = 1'b0; cmd_ctrl = 1'b0;
    rdy = '1;
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  logic          mv [NP];
  logic [31:0]   md [NP];
  logic          ml [NP];
  logic          mc;

  initial begin
    do_reset();
    chk(m_tvalid == '0, "R1 tvalid", 64'(m_tvalid), 0);
    chk(stall == 1'b0, "R1 stall", 64'(stall), 0);
    chk(carry == 1'b0, "R1 carry", 64'(carry), 0);
    rst_n = 1'b1;

    // vector walk, all ports ready
    for (int i = 0; i < 8; i++) begin
      cmd_valid = 1'b1;
      {cmd_port, cmd_nb, cmd_ctrl, cmd_data} = VEC[i];
      #1;
      chk(stall == 1'b0, "R2/R4 stall low on free port", 64'(stall), 0);
      step();
      chk(m_tvalid == (16'd1 << cmd_port), "R9 only selected port valid", 64'(m_tvalid), 64'(16'd1 << cmd_port));
      chk(pdata(int'(cmd_port)) == cmd_data, "R2 data", 64'(pdata(int'(cmd_port))), 64'(cmd_data));
      chk(m_tlast[cmd_port] == cmd_ctrl, "R6 last", 64'(m_tlast[cmd_port]), 64'(cmd_ctrl));
      if (cmd_nb) chk(carry == 1'b0, "R5 carry clear", 64'(carry), 0);
    end
    cmd_valid = 1'b0;
    step();
    chk(m_tvalid == '0, "R8 drop after beat", 64'(m_tvalid), 0);

    // blocking write into backpressure
    rdy[3] = 1'b0;
    cmd_valid = 1'b1; cmd_port = 4'd3; cmd_nb = 1'b0; cmd_ctrl = 1'b0; cmd_data = 32'hA1;
    step();
    chk(m_tvalid[3] && pdata(3) == 32'hA1, "R2 load port3", 64'(pdata(3)), 64'hA1);
    cmd_data = 32'hB2; cmd_ctrl = 1'b1;
    #1;
    chk(stall == 1'b1, "R3 stall on busy", 64'(stall), 1);
    step();
    chk(stall == 1'b1, "R3 stall held", 64'(stall), 1);
    chk(pdata(3) == 32'hA1 && m_tlast[3] == 1'b0 && m_tvalid[3], "R7 hold stable", 64'(pdata(3)), 64'hA1);
    rdy[3] = 1'b1;
    #1;
    chk(stall == 1'b0, "R3 stall release", 64'(stall), 0);
    step();
    chk(m_tvalid[3] && pdata(3) == 32'hB2, "R3 new beat", 64'(pdata(3)), 64'hB2);
    chk(m_tlast[3] == 1'b1, "R6 ctrl last", 64'(m_tlast[3]), 1);

    // non-blocking into busy port
    rdy[3] = 1'b0;
    cmd_nb = 1'b1; cmd_ctrl = 1'b0; cmd_data = 32'hC3;
    #1;
    chk(stall == 1'b0, "R4 no stall", 64'(stall), 0);
    step();
    chk(pdata(3) == 32'hB2 && m_tlast[3] == 1'b1 && m_tvalid[3], "R4 port untouched", 64'(pdata(3)), 64'hB2);
    chk(carry == 1'b1, "R4 carry set", 64'(carry), 1);

    // blocking write keeps carry
    cmd_nb = 1'b0; cmd_port = 4'd5; cmd_data = 32'hD4;
    step();
    chk(carry == 1'b1, "R10 carry kept", 64'(carry), 1);
    chk(m_tvalid == 16'h0028, "R9 other port unchanged", 64'(m_tvalid), 64'h28);

    // non-blocking success on valid-but-ready port
    cmd_nb = 1'b1; cmd_data = 32'hE5;
    step();
    chk(carry == 1'b0, "R5 carry cleared", 64'(carry), 0);
    chk(pdata(5) == 32'hE5, "R5 data loaded", 64'(pdata(5)), 64'hE5);
    cmd_valid = 1'b0;
    step();
    chk(m_tvalid[5] == 1'b0, "R8 port5 idle", 64'(m_tvalid[5]), 0);
    chk(m_tvalid[3] && pdata(3) == 32'hB2, "R7 port3 still waiting", 64'(pdata(3)), 64'hB2);

    // random backpressure against a model
    do_reset();
    rst_n = 1'b1;
    for (int p = 0; p < NP; p++) begin mv[p] = 0; md[p] = '0; ml[p] = 0; end
    mc = 0;
    begin
      bit hold = 0;
      for (int c = 0; c < 400; c++) begin
        bit eb;
        int sp;
        rdy = 16'($urandom);
        if (!hold) begin
          cmd_valid = ($urandom % 4) != 0;
          cmd_port  = 4'($urandom);
          cmd_nb    = 1'($urandom);
          cmd_ctrl  = 1'($urandom);
          cmd_data  = $urandom;
        end
        #1;
        sp = int'(cmd_port);
        eb = mv[sp] && !rdy[sp];
        chk(stall == (cmd_valid && !cmd_nb && eb), "R3 random stall", 64'(stall), 64'(cmd_valid && !cmd_nb && eb));
        for (int p = 0; p < NP; p++) begin
          if (cmd_valid && p == sp && !eb) begin
            mv[p] = 1; md[p] = cmd_data; ml[p] = cmd_ctrl;
          end else if (rdy[p]) mv[p] = 0;
        end
        if (cmd_valid && cmd_nb) mc = eb;
        hold = cmd_valid && !cmd_nb && eb;
        step();
        for (int p = 0; p < NP; p++) begin
          chk(m_tvalid[p] == mv[p], "R9 random valid", 64'(m_tvalid[p]), 64'(mv[p]));
          if (mv[p]) begin
            chk(pdata(p) == md[p], "R7 random data", 64'(pdata(p)), 64'(md[p]));
            chk(m_tlast[p] == ml[p], "R6 random last", 64'(m_tlast[p]), 64'(ml[p]));
          end
        end
        chk(carry == mc, "R4 random carry", 64'(carry), 64'(mc));
      end
    end
    cmd_valid = 1'b0;
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog act=0 exp=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule